// File: doc/BRIEF.md
# Same-Cycle Store/Load Data RAM

This block is a synchronous on-chip data memory of 16-bit words. In every clock cycle it takes one write and one read from the processor with no stall. Each cycle is treated as two halves: the store is committed in the first half and the load is served in the second. A load therefore always sees a store made in the same cycle, and a store-then-load pair to one word completes in a single cycle and returns the fresh value.

Both ports are sampled on the rising clock edge. The read result is registered and appears in the cycle after the request, qualified by a valid flag. The depth is a parameter. The address ports may be wider than the depth needs: a write above the last word is dropped, and a read above it returns zero. A cycle that carries only a write, or only a read, behaves like an ordinary single-port access.

Top module: `split_phase_ram`

## Requirements
- R1: While reset is asserted and after it is released, `rd_valid_o` is 0 and `rd_data_o` is 0 until the first read is served.
- R2: A write with `we_i`=1 to an address below `DEPTH` stores `wr_data_i`. A later read of that address returns the stored word.
- R3: `rd_valid_o` is 1 in the cycle after a cycle with `re_i`=1 and 0 in the cycle after a cycle with `re_i`=0. The read data is presented in that same following cycle.
- R4: When `we_i` and `re_i` are both 1 and `wr_addr_i` equals `rd_addr_i` below `DEPTH`, the read returns that cycle's `wr_data_i` (write-first).
- R5: When a write and a read to different in-range addresses share a cycle, the read returns the word held before that cycle, and the write still lands.
- R6: A write to an address at or above `DEPTH` changes no stored word.
- R7: A read of an address at or above `DEPTH` returns 0.
- R8: In a cycle after `re_i`=0, `rd_data_o` keeps the value it had.
- R9: With `we_i`=0, `wr_addr_i` and `wr_data_i` change no stored word.
- R10: A same-cycle write and read to the same address at or above `DEPTH` returns 0. No forwarding takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write enable |
| wr_addr_i | input | ADDR_W | Write word address |
| wr_data_i | input | 16 | Write data |
| re_i | input | 1 | Read enable |
| rd_addr_i | input | ADDR_W | Read word address |
| rd_data_o | output | 16 | Registered read data |
| rd_valid_o | output | 1 | Read data valid, one cycle after `re_i` |

## Verification
Stored contents change at the rising edge that samples the write. Every read result, including a forwarded one, is due exactly one edge after the request. The bench drives each request on a falling edge and samples `rd_data_o` and `rd_valid_o` on the following falling edge. That point lies after the single register stage and before the next request can disturb it. Dropped and disabled writes are checked by reading every address back on later cycles, and held data is checked across idle cycles.

// File: rtl/spr_pkg.sv
package spr_pkg;
  localparam int unsigned WORD_W = 16;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/spr_range_dec.sv
module spr_range_dec #(
  parameter int unsigned DEPTH  = 512,
  parameter int unsigned ADDR_W = 10
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  always_comb hit_o = (32'(addr_i) < DEPTH);
endmodule

// File: rtl/spr_bank.sv
module spr_bank
  import spr_pkg::*;
#(
  parameter int unsigned DEPTH  = 512,
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_idx_i,
  input  word_t             wr_data_i,
  input  logic [ADDR_W-1:0] rd_idx_i,
  output word_t             rd_word_o
);
  word_t mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_idx_i] <= wr_data_i;
  end

  // pre-edge contents; forwarding is resolved in the read stage
  always_comb rd_word_o = mem_q[rd_idx_i];

  p_write_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_en_i) |-> mem_q[$past(wr_idx_i)] == $past(wr_data_i));
endmodule

// File: rtl/spr_read_stage.sv
module spr_read_stage
  import spr_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  re_i,
  input  logic  rd_hit_i,
  input  logic  fwd_i,
  input  word_t wr_data_i,
  input  word_t bank_word_i,
  output word_t rd_data_o,
  output logic  rd_valid_o
);
  word_t next_word;

  always_comb begin
    if (!rd_hit_i)  next_word = '0;
    else if (fwd_i) next_word = wr_data_i;  // first-phase write wins
    else            next_word = bank_word_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= re_i;
      if (re_i) rd_data_o <= next_word;
    end
  end

  p_hold_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(re_i) |-> $stable(rd_data_o));
endmodule

// File: rtl/split_phase_ram.sv
module split_phase_ram
  import spr_pkg::*;
#(
  parameter int unsigned DEPTH  = 512,
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [15:0]       wr_data_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [15:0]       rd_data_o,
  output logic              rd_valid_o
);
  localparam int unsigned MIN_AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  initial begin
    if (ADDR_W < MIN_AW) $error("ADDR_W too small for DEPTH");
  end

  logic  wr_hit, rd_hit, wr_en, fwd;
  word_t bank_word;

  spr_range_dec #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_wr_dec (
    .addr_i(wr_addr_i), .hit_o(wr_hit));
  spr_range_dec #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_rd_dec (
    .addr_i(rd_addr_i), .hit_o(rd_hit));

  always_comb begin
    wr_en = we_i && wr_hit;
    fwd   = wr_en && rd_hit && (wr_addr_i == rd_addr_i);
  end

  spr_bank #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_bank (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_idx_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_idx_i(rd_addr_i), .rd_word_o(bank_word));

  spr_read_stage u_rd (
    .clk_i, .rst_ni, .re_i, .rd_hit_i(rd_hit), .fwd_i(fwd),
    .wr_data_i(wr_data_i), .bank_word_i(bank_word),
    .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o));

  p_same_word_fwd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(re_i && we_i && wr_hit && rd_hit && wr_addr_i == rd_addr_i)
      |-> rd_data_o == $past(wr_data_i));
  p_oor_read_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(re_i && !rd_hit) |-> rd_data_o == '0);
  p_valid_tracks_req_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(re_i) |-> rd_valid_o);
endmodule

// File: tb/split_phase_ram_bench.sv
module split_phase_ram_bench;
  localparam int D  = 20;
  localparam int AW = 5;
  localparam int NA = 1 << AW;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic we = 1'b0, re = 1'b0;
  logic [AW-1:0] wa = '0, ra = '0;
  logic [15:0] wd = '0;
  logic [15:0] rd_data;
  logic rd_valid;

  int checks = 0, errors = 0;
  logic [15:0] model [D];
  logic [15:0] last_data = '0;

  always #2ns clk = ~clk;

  split_phase_ram #(.DEPTH(D), .ADDR_W(AW)) u_split_phase_ram (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we), .wr_addr_i(wa), .wr_data_i(wd),
    .re_i(re), .rd_addr_i(ra), .rd_data_o(rd_data), .rd_valid_o(rd_valid));

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one cycle: drive on falling edge, sample on next falling edge
  task automatic cyc(string req, bit w, int waddr, logic [15:0] wdat,
                     bit r, int raddr);
    logic [15:0] exp;
    exp = last_data;
    if (r) begin
      if (raddr >= D) exp = '0;
      else if (w && waddr == raddr) exp = wdat;
      else exp = model[raddr];
    end
    we = w; wa = AW'(waddr); wd = wdat; re = r; ra = AW'(raddr);
    @(negedge clk);
    if (w && waddr < D) model[waddr] = wdat;
    chk({req, " valid"}, {15'd0, rd_valid}, {15'd0, r});
    chk(req, rd_data, exp);
    last_data = exp;
    we = 0; re = 0;
  endtask

  function automatic logic [15:0] pat(int a, int s);
    return 16'((a * 16'h0101) ^ (s * 16'h3C5A) ^ 16'hA500);
  endfunction

  initial begin
    #(200000 * 4ns);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", {15'd0, rd_valid}, 16'd0);
    chk("R1 data in reset", rd_data, 16'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", {15'd0, rd_valid}, 16'd0);
    chk("R1 data after reset", rd_data, 16'd0);

    // fill, including out-of-range writes (R2, R6)
    for (int a = 0; a < NA; a++) cyc("R6 fill", 1, a, pat(a, 1), 0, 0);
    for (int a = 0; a < NA; a++)
      cyc(a < D ? "R2 readback" : "R7 oor read", 0, 0, 0, 1, a);

    // idle hold (R8, R3)
    cyc("R3 read", 0, 0, 0, 1, 7);
    for (int i = 0; i < 4; i++) cyc("R8 hold", 0, 0, 16'hFFFF, 0, i);

    // disabled write (R9)
    for (int a = 0; a < D; a++) begin
      we = 0; wa = AW'(a); wd = ~pat(a, 1); re = 0;
      @(negedge clk);
    end
    for (int a = 0; a < D; a++) cyc("R9 no-we", 0, 0, 0, 1, a);

    // same-cycle write and read to the same word (R4, R10)
    for (int a = 0; a < NA; a++)
      cyc(a < D ? "R4 same word" : "R10 oor same", 1, a, pat(a, 2), 1, a);

    // same-cycle write and read to different words (R5)
    for (int a = 0; a < D; a++)
      cyc("R5 split", 1, a, pat(a, 3), 1, (a + 1) % D);

    for (int a = 0; a < NA; a++)
      cyc(a < D ? "R5 final" : "R7 final", 0, 0, 0, 1, a);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule